// File: doc/BRIEF.md
# UART Register Front End

This block is the 32-bit bus-facing register layer of a simple UART. Software sees a transmit data port, a receive data port backed by a small FIFO, two control registers that each carry a 3-bit watermark count, an interrupt-enable register, a read-only interrupt-pending register and a baud divisor register. The serial shifter and the baud tick generator sit outside this block. This block only stores the divisor for them.

The receive side takes bytes from a byte-wide valid input and queues them. A ready output tells the source whether there is room. Reading the receive data register pops the oldest byte. If the queue is empty, the read returns a word with bit 31 set. Each write to the transmit data register produces a one-cycle strobe that carries the low byte. A single level interrupt output combines the enable bits with the queue state.

The bus uses one request per cycle: valid, write, address and write data. The read data and a read-valid flag appear on the cycle after a read request. The FIFO depth must be a power of two.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the following state holds. The enable, both control and divisor registers read 0. The receive data port reads 0x80000000. `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: A read of offset 0x04 while the FIFO holds data returns the oldest byte in bits [7:0] with the upper bits zero, and removes that byte. Bytes come out in arrival order.
- R3: A read of offset 0x04 while the FIFO is empty returns 0x80000000 and leaves the FIFO unchanged.
- R4: A write to offset 0x00 raises `tx_valid` for exactly the next cycle, with `tx_byte` equal to bits [7:0] of the write data. A read of offset 0x00 returns 0.
- R5: Offsets 0x08 (transmit control), 0x0C (receive control), 0x10 (interrupt enable) and 0x18 (divisor) each read back the last full 32-bit value written.
- R6: Bit 0 of the pending register at offset 0x14 is 1 exactly when bits [18:16] of the transmit control register are nonzero.
- R7: Bit 1 of the pending register is 1 exactly when the FIFO occupancy is strictly greater than bits [18:16] of the receive control register. All other pending bits read 0.
- R8: `irq` is high when interrupt-enable bit 0 is set. It is also high when interrupt-enable bit 1 is set and the FIFO is not empty. Otherwise it is low.
- R9: The FIFO holds 8 bytes. `rx_ready` is low exactly when it is full. A byte offered while the FIFO is full is dropped, and the stored contents stay unchanged.
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing. Writes to the pending register at 0x14 are ignored.
- R11: Read data and `bus_rvalid` appear on the cycle after the read request. `bus_rvalid` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (5) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| rx_valid | input | 1 | Incoming byte present |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO not full |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the FIFO to every occupancy from 0 to 8. At each level it sweeps the receive watermark over all eight values and the enable register over all four combinations. This exposes an off-by-one in the strictly-greater watermark compare, which would flag pending one byte early. It also exposes an interrupt that ignores the empty-FIFO gate on the receive enable. Overfilling by one byte catches a FIFO that wraps and overwrites its oldest entry, or one that lets a ninth byte through. Draining past empty catches an empty read that returns stale data instead of the bit-31 flag, or one that moves the read pointer. Writes to unmapped offsets and to the pending register are followed by readback of every register, to catch address decoding that aliases onto a real register.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] OFF_TX  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_RX  = AW'(8'h04);
  localparam logic [AW-1:0] OFF_TXC = AW'(8'h08);
  localparam logic [AW-1:0] OFF_RXC = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_IE  = AW'(8'h10);
  localparam logic [AW-1:0] OFF_IP  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_DIV = AW'(8'h18);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [31:0]   ie_q, txc_q, rxc_q, div_q, pend, rsel;

  wire rd    = bus_valid & ~bus_write;
  wire wr    = bus_valid &  bus_write;
  wire empty = (cnt == '0);
  wire full  = (cnt == CW'(DEPTH));
  wire push  = rx_valid & ~full;
  wire pop   = rd & (bus_addr == OFF_RX) & ~empty;

  assign rx_ready = ~full;
  assign irq      = ie_q[0] | (ie_q[1] & ~empty);
  assign pend     = {30'b0, 32'(cnt) > 32'(rxc_q[18:16]), txc_q[18:16] != 3'b0};

  always_comb begin
    case (bus_addr)
      OFF_RX:  rsel = empty ? 32'h8000_0000 : {24'b0, mem[rp]};
      OFF_TXC: rsel = txc_q;
      OFF_RXC: rsel = rxc_q;
      OFF_IE:  rsel = ie_q;
      OFF_IP:  rsel = pend;
      OFF_DIV: rsel = div_q;
      default: rsel = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q       <= '0;
      txc_q      <= '0;
      rxc_q      <= '0;
      div_q      <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rsel;
      tx_valid <= wr && (bus_addr == OFF_TX);
      if (wr) begin
        case (bus_addr)
          OFF_TX:  tx_byte <= bus_wdata[7:0];
          OFF_TXC: txc_q   <= bus_wdata;
          OFF_RXC: rxc_q   <= bus_wdata;
          OFF_IE:  ie_q    <= bus_wdata;
          OFF_DIV: div_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH);
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && !pop) |=> (cnt == $past(cnt)) && !rx_ready);
  a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rx_valid) |=> (32'(cnt) + 1 == 32'($past(cnt))));
  a_r3_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == OFF_RX && empty) |=> (bus_rdata == 32'h8000_0000));
  a_r4_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFF_TX) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));
  a_r8_tx_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q[0] |-> irq);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q[0] && empty) |-> !irq);
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
endmodule

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, rx_valid = 1'b0, rx_ready, tx_valid, irq;
  logic [7:0] rx_byte = '0, tx_byte;
  int total = 0, bad = 0;
  logic [31:0] v;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    chk(bus_rvalid === 1'b1, "R11 rvalid", 32'(bus_rvalid), 1);
    @(posedge clk); @(negedge clk);
    chk(bus_rvalid === 1'b0, "R11 rvalid one cycle", 32'(bus_rvalid), 0);
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((k * 37 + i * 5 + 1) & 8'hFF);
  endfunction

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq === 1'b0 && tx_valid === 1'b0 && rx_ready === 1'b1, "R1 outputs",
        {29'b0, irq, tx_valid, rx_ready}, 32'h1);
    rd(5'h08, v); chk(v === 0, "R1 txctrl", v, 0);
    rd(5'h0C, v); chk(v === 0, "R1 rxctrl", v, 0);
    rd(5'h10, v); chk(v === 0, "R1 ie", v, 0);
    rd(5'h18, v); chk(v === 0, "R1 div", v, 0);
    rd(5'h04, v); chk(v === 32'h8000_0000, "R1 rx empty", v, 32'h8000_0000);

    // R5 readback
    wr(5'h18, 32'hA5A5_1234); rd(5'h18, v); chk(v === 32'hA5A5_1234, "R5 div", v, 32'hA5A5_1234);
    wr(5'h10, 32'hF0F0_0000); rd(5'h10, v); chk(v === 32'hF0F0_0000, "R5 ie", v, 32'hF0F0_0000);
    wr(5'h10, 32'h0);

    // R6 transmit watermark sweep
    for (int t = 0; t < 8; t++) begin
      wr(5'h08, (32'(t) << 16) | 32'h5);
      rd(5'h08, v); chk(v === ((32'(t) << 16) | 32'h5), "R5 txctrl", v, (32'(t) << 16) | 32'h5);
      rd(5'h14, v); chk(v[0] === (t != 0), "R6 txwm", v, 32'(t != 0));
    end
    wr(5'h08, 32'h0);

    // R4 transmit strobe
    for (int b = 0; b < 256; b += 51) begin
      wr(5'h00, 32'hFFFF_FF00 | 32'(b));
      chk(tx_valid === 1'b1 && tx_byte === 8'(b), "R4 tx strobe", {23'b0, tx_valid, tx_byte}, {23'b0, 1'b1, 8'(b)});
      @(posedge clk); @(negedge clk);
      chk(tx_valid === 1'b0, "R4 tx one cycle", 32'(tx_valid), 0);
    end
    rd(5'h00, v); chk(v === 0, "R4 tx read zero", v, 0);

    // R7 / R8 / R2 / R3 occupancy sweep
    for (int k = 0; k <= 8; k++) begin
      for (int i = 0; i < k; i++) push(pat(k, i));
      chk(rx_ready === (k < 8), "R9 ready", 32'(rx_ready), 32'(k < 8));
      for (int t = 0; t < 8; t++) begin
        wr(5'h0C, (32'(t) << 16) | 32'h3);
        rd(5'h14, v); chk(v === {30'b0, k > t, 1'b0}, "R7 rxwm", v, {30'b0, k > t, 1'b0});
        rd(5'h0C, v); chk(v === ((32'(t) << 16) | 32'h3), "R5 rxctrl", v, (32'(t) << 16) | 32'h3);
      end
      for (int e = 0; e < 4; e++) begin
        wr(5'h10, 32'(e));
        chk(irq === ((e & 1) != 0 || ((e & 2) != 0 && k > 0)), "R8 irq", 32'(irq),
            32'((e & 1) != 0 || ((e & 2) != 0 && k > 0)));
      end
      wr(5'h10, 32'h0);
      for (int i = 0; i < k; i++) begin
        rd(5'h04, v); chk(v === {24'b0, pat(k, i)}, "R2 fifo order", v, {24'b0, pat(k, i)});
      end
      rd(5'h04, v); chk(v === 32'h8000_0000, "R3 empty flag", v, 32'h8000_0000);
      rd(5'h04, v); chk(v === 32'h8000_0000, "R3 empty again", v, 32'h8000_0000);
    end

    // R9 overfill drop
    for (int i = 0; i < 9; i++) push(8'(8'hC0 + i));
    chk(rx_ready === 1'b0, "R9 full ready", 32'(rx_ready), 0);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, v); chk(v === {24'b0, 8'(8'hC0 + i)}, "R9 kept contents", v, {24'b0, 8'(8'hC0 + i)});
    end
    rd(5'h04, v); chk(v === 32'h8000_0000, "R9 extra dropped", v, 32'h8000_0000);

    // R10 unmapped and pending writes
    wr(5'h1C, 32'hDEAD_BEEF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'h1234_5678);
    rd(5'h1C, v); chk(v === 0, "R10 unmapped read", v, 0);
    rd(5'h02, v); chk(v === 0, "R10 misaligned read", v, 0);
    rd(5'h14, v); chk(v === 0, "R10 ip read-only", v, 0);
    rd(5'h18, v); chk(v === 32'hA5A5_1234, "R10 div intact", v, 32'hA5A5_1234);
    rd(5'h10, v); chk(v === 0, "R10 ie intact", v, 0);
    rd(5'h08, v); chk(v === 0, "R10 txctrl intact", v, 0);
    rd(5'h0C, v); chk(v === 32'h0007_0003, "R10 rxctrl intact", v, 32'h0007_0003);
    chk(irq === 1'b0 && tx_valid === 1'b0, "R10 outputs quiet", {30'b0, irq, tx_valid}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule